// File: doc/BRIEF.md
# Exception Entry Controller

This block sits next to a simple 32-bit processor pipeline and performs all state changes needed when control passes to an exception handler. Entry is triggered either by a take strobe from the pipeline, which carries a cause code for a synchronous exception, or by one of two interrupt request lines (an external interrupt and a tick timer). The block owns the status register. On an entry it saves the return address and the status register. It then rewrites the mode bits, produces the handler fetch address, and sends a one-cycle request to flush the translation buffers.

The return address is the current PC. It is moved back one instruction when the trapping instruction sits in a delay slot, and forward one instruction for a system call, so that the handler returns to the instruction after the call. Each handler starts at the cause number times 256. A take strobe that carries an undefined cause does not redirect anything. It raises a sticky error, and the block then stops until reset.

The control state machine has two states. In ST_RUN the block accepts entries and status writes. It moves from ST_RUN to ST_HALT when it sees an illegal cause, and otherwise stays in ST_RUN. ST_HALT holds until reset, and reset always returns the machine to ST_RUN.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Synchronous active-low reset sets the status register to 0x0001 (only bit 0, supervisor, set), clears the saved PC, saved status, vector, cause output, flush, delay-slot clear and error outputs, and enters ST_RUN.
- R2: On entry the saved PC equals the current PC, less 4 when the delay-slot input is high, plus 4 when the entry is a synchronous one with the system-call cause (12).
- R3: On an entry with the delay-slot input high, status bit 5 (delay-slot exception) is set and the delay-slot clear output pulses for one cycle; without a delay slot, bit 5 keeps its previous value.
- R4: On entry the saved status output takes the status register value held just before the entry.
- R5: On entry status bits 1 (interrupt enable), 2 (tick enable), 3 (data translation enable) and 4 (instruction translation enable) are cleared, bit 0 (supervisor) is set, and bits 6 to 15 are kept.
- R6: On entry the vector output equals the entered cause shifted left by 8 bits.
- R7: A take strobe with cause 0 or a cause of 14 or more sets the error output, leaves all registers unchanged, gives no flush, and moves to ST_HALT, where takes, interrupts and status writes have no effect until reset.
- R8: The external interrupt (cause 8) enters only when status bit 1 is set and the tick interrupt (cause 5) only when status bit 2 is set; when both are pending and enabled, the tick interrupt is entered.
- R9: The flush output is high for exactly the one cycle after each entry edge.
- R10: A take strobe takes precedence over pending interrupts and over a status write in the same cycle.
- R11: The cause output shows the entered cause during the flush cycle and is 0 in every other cycle.
- R12: In ST_RUN without an entry, a status write loads the written value into the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | PC of the instruction being trapped |
| dslot_i | input | 1 | Trapped instruction is in a delay slot |
| take_i | input | 1 | Synchronous exception strobe |
| cause_i | input | 4 | Cause code qualifying take_i |
| ext_irq_i | input | 1 | External interrupt request |
| tick_irq_i | input | 1 | Tick timer interrupt request |
| sr_wr_i | input | 1 | Status register write from the pipeline |
| sr_wdata_i | input | 16 | Status write data |
| sr_o | output | 16 | Current status register |
| esr_o | output | 16 | Saved status register |
| epc_o | output | 32 | Saved return PC |
| npc_o | output | 32 | Handler fetch address |
| cause_o | output | 4 | Cause entered, 0 when idle |
| flush_o | output | 1 | One-cycle translation flush and redirect |
| dslot_clr_o | output | 1 | One-cycle request to clear the delay-slot flag |
| err_o | output | 1 | Sticky illegal-cause error |

## Verification
The bench uses the default parameters: a 4-bit cause with 14 defined causes, a 16-bit status register and the system call at cause 12. With these values every code from 0 to 15 can be swept. This covers cause zero and both undefined codes, and every legal cause is entered with and without a delay slot, so both PC adjustments and the case where they cancel are exercised. The interrupt enable bits are swept across all combinations of pending lines, and same-cycle conflicts are checked between the take strobe, the interrupts and a status write.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } ctrl_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SYNC = 2'd1,
        SRC_TICK = 2'd2,
        SRC_EXT  = 2'd3
    } entry_src_e;

    localparam int SR_SUP  = 0;
    localparam int SR_IEN  = 1;
    localparam int SR_TEN  = 2;
    localparam int SR_DMMU = 3;
    localparam int SR_IMMU = 4;
    localparam int SR_DSX  = 5;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int CAUSE_W    = 4,
    parameter int NUM_CAUSES = 14,
    parameter int TICK_CAUSE = 5,
    parameter int EXT_CAUSE  = 8
) (
    input  logic               take_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               ext_irq_i,
    input  logic               tick_irq_i,
    input  logic               ien_i,
    input  logic               ten_i,
    output entry_src_e         src_o,
    output logic [CAUSE_W-1:0] sel_cause_o,
    output logic               illegal_o
);

    localparam logic [CAUSE_W-1:0] TICK_CODE = CAUSE_W'(TICK_CAUSE);
    localparam logic [CAUSE_W-1:0] EXT_CODE  = CAUSE_W'(EXT_CAUSE);

    always_comb begin
        src_o       = SRC_NONE;
        sel_cause_o = '0;
        illegal_o   = 1'b0;
        if (take_i) begin
            src_o       = SRC_SYNC;
            sel_cause_o = cause_i;
            illegal_o   = (cause_i == '0) || (int'(cause_i) >= NUM_CAUSES);
        end else if (tick_irq_i && ten_i) begin
            src_o       = SRC_TICK;
            sel_cause_o = TICK_CODE;
        end else if (ext_irq_i && ien_i) begin
            src_o       = SRC_EXT;
            sel_cause_o = EXT_CODE;
        end
    end

endmodule

// File: rtl/exc_pc_calc.sv
module exc_pc_calc #(
    parameter int XLEN          = 32,
    parameter int CAUSE_W       = 4,
    parameter int SYSCALL_CAUSE = 12,
    parameter int VEC_SHIFT     = 8
) (
    input  logic [XLEN-1:0]    pc_i,
    input  logic               dslot_i,
    input  logic               is_sync_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [XLEN-1:0]    epc_o,
    output logic [XLEN-1:0]    vec_o
);

    localparam logic [XLEN-1:0]    INSN_BYTES = XLEN'(4);
    localparam logic [CAUSE_W-1:0] SYS_CODE   = CAUSE_W'(SYSCALL_CAUSE);

    logic [XLEN-1:0] back_adj;
    logic [XLEN-1:0] fwd_adj;

    always_comb begin
        back_adj = dslot_i ? INSN_BYTES : '0;
        fwd_adj  = (is_sync_i && (cause_i == SYS_CODE)) ? INSN_BYTES : '0;
        epc_o    = pc_i - back_adj + fwd_adj;
        vec_o    = {{(XLEN-CAUSE_W){1'b0}}, cause_i} << VEC_SHIFT;
    end

endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
    import exc_entry_pkg::*;
#(
    parameter int SR_W = 16
) (
    input  logic [SR_W-1:0] sr_i,
    input  logic            dslot_i,
    output logic [SR_W-1:0] sr_o
);

    for (genvar b = 0; b < SR_W; b++) begin : g_bit
        if (b == SR_SUP) begin : g_set
            assign sr_o[b] = 1'b1;
        end else if (b == SR_IEN || b == SR_TEN || b == SR_DMMU || b == SR_IMMU) begin : g_clr
            assign sr_o[b] = 1'b0;
        end else if (b == SR_DSX) begin : g_dsx
            assign sr_o[b] = sr_i[b] | dslot_i;
        end else begin : g_keep
            assign sr_o[b] = sr_i[b];
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN          = 32,
    parameter int SR_W          = 16,
    parameter int CAUSE_W       = 4,
    parameter int NUM_CAUSES    = 14,
    parameter int SYSCALL_CAUSE = 12,
    parameter int TICK_CAUSE    = 5,
    parameter int EXT_CAUSE     = 8,
    parameter int VEC_SHIFT     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XLEN-1:0]    pc_i,
    input  logic               dslot_i,
    input  logic               take_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               ext_irq_i,
    input  logic               tick_irq_i,
    input  logic               sr_wr_i,
    input  logic [SR_W-1:0]    sr_wdata_i,
    output logic [SR_W-1:0]    sr_o,
    output logic [SR_W-1:0]    esr_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [XLEN-1:0]    npc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               flush_o,
    output logic               dslot_clr_o,
    output logic               err_o
);

    localparam logic [SR_W-1:0] SR_RESET = SR_W'(1) << SR_SUP;

    ctrl_state_e          state_q, state_d;
    entry_src_e           src;
    logic [CAUSE_W-1:0]   sel_cause;
    logic                 illegal;
    logic [XLEN-1:0]      epc_calc;
    logic [XLEN-1:0]      vec_calc;
    logic [SR_W-1:0]      sr_entry;
    logic                 do_entry;

    exc_arbiter #(
        .CAUSE_W    (CAUSE_W),
        .NUM_CAUSES (NUM_CAUSES),
        .TICK_CAUSE (TICK_CAUSE),
        .EXT_CAUSE  (EXT_CAUSE)
    ) u_arb (
        .take_i      (take_i),
        .cause_i     (cause_i),
        .ext_irq_i   (ext_irq_i),
        .tick_irq_i  (tick_irq_i),
        .ien_i       (sr_o[SR_IEN]),
        .ten_i       (sr_o[SR_TEN]),
        .src_o       (src),
        .sel_cause_o (sel_cause),
        .illegal_o   (illegal)
    );

    exc_pc_calc #(
        .XLEN          (XLEN),
        .CAUSE_W       (CAUSE_W),
        .SYSCALL_CAUSE (SYSCALL_CAUSE),
        .VEC_SHIFT     (VEC_SHIFT)
    ) u_pc (
        .pc_i      (pc_i),
        .dslot_i   (dslot_i),
        .is_sync_i (src == SRC_SYNC),
        .cause_i   (sel_cause),
        .epc_o     (epc_calc),
        .vec_o     (vec_calc)
    );

    exc_sr_update #(
        .SR_W (SR_W)
    ) u_sr (
        .sr_i    (sr_o),
        .dslot_i (dslot_i),
        .sr_o    (sr_entry)
    );

    assign do_entry = (state_q == ST_RUN) && (src != SRC_NONE) && !illegal;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (src == SRC_SYNC && illegal) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_o        <= SR_RESET;
            esr_o       <= '0;
            epc_o       <= '0;
            npc_o       <= '0;
            cause_o     <= '0;
            flush_o     <= 1'b0;
            dslot_clr_o <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            flush_o     <= 1'b0;
            dslot_clr_o <= 1'b0;
            cause_o     <= '0;
            unique case (state_q)
                ST_RUN: begin
                    if (do_entry) begin
                        epc_o       <= epc_calc;
                        esr_o       <= sr_o;
                        sr_o        <= sr_entry;
                        npc_o       <= vec_calc;
                        cause_o     <= sel_cause;
                        flush_o     <= 1'b1;
                        dslot_clr_o <= dslot_i;
                    end else if (src == SRC_SYNC) begin
                        err_o <= 1'b1;
                    end else if (sr_wr_i) begin
                        sr_o <= sr_wdata_i;
                    end
                end
                ST_HALT: begin
                    err_o <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int SR_W       = 16,
    parameter int CAUSE_W    = 4,
    parameter int TICK_CAUSE = 5,
    parameter int EXT_CAUSE  = 8,
    parameter int VEC_SHIFT  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               take_i,
    input logic [SR_W-1:0]    sr_o,
    input logic [SR_W-1:0]    esr_o,
    input logic [XLEN-1:0]    npc_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic               flush_o,
    input logic               dslot_clr_o,
    input logic               err_o
);

    // R3: delay-slot clear only accompanies an entry that marks the status bit
    p_dsx_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dslot_clr_o |-> (flush_o && sr_o[SR_DSX]));

    p_esr_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (esr_o == $past(sr_o)));

    p_mode_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (sr_o[SR_SUP] && !sr_o[SR_IEN] && !sr_o[SR_TEN]
                     && !sr_o[SR_DMMU] && !sr_o[SR_IMMU]));

    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (npc_o == ({{(XLEN-CAUSE_W){1'b0}}, cause_o} << VEC_SHIFT)));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !flush_o);

    p_ext_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && cause_o == CAUSE_W'(EXT_CAUSE) && !$past(take_i)) |-> $past(sr_o[SR_IEN]));

    p_tick_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && cause_o == CAUSE_W'(TICK_CAUSE) && !$past(take_i)) |-> $past(sr_o[SR_TEN]));

    p_flush_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    p_cause_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_o |-> (cause_o == '0));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN       (XLEN),
    .SR_W       (SR_W),
    .CAUSE_W    (CAUSE_W),
    .TICK_CAUSE (TICK_CAUSE),
    .EXT_CAUSE  (EXT_CAUSE),
    .VEC_SHIFT  (VEC_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_i),
    .sr_o        (sr_o),
    .esr_o       (esr_o),
    .npc_o       (npc_o),
    .cause_o     (cause_o),
    .flush_o     (flush_o),
    .dslot_clr_o (dslot_clr_o),
    .err_o       (err_o)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic        dslot_i = 1'b0;
    logic        take_i = 1'b0;
    logic [3:0]  cause_i = '0;
    logic        ext_irq_i = 1'b0;
    logic        tick_irq_i = 1'b0;
    logic        sr_wr_i = 1'b0;
    logic [15:0] sr_wdata_i = '0;
    logic [15:0] sr_o, esr_o;
    logic [31:0] epc_o, npc_o;
    logic [3:0]  cause_o;
    logic        flush_o, dslot_clr_o, err_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .dslot_i(dslot_i), .take_i(take_i),
        .cause_i(cause_i), .ext_irq_i(ext_irq_i), .tick_irq_i(tick_irq_i),
        .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i), .sr_o(sr_o), .esr_o(esr_o),
        .epc_o(epc_o), .npc_o(npc_o), .cause_o(cause_o), .flush_o(flush_o),
        .dslot_clr_o(dslot_clr_o), .err_o(err_o)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_sr(logic [15:0] s, logic ds);
        return (s & 16'hFFE1) | 16'h0001 | (ds ? 16'h0020 : 16'h0000);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; take_i = 0; ext_irq_i = 0; tick_irq_i = 0; sr_wr_i = 0; dslot_i = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_sr(logic [15:0] v);
        sr_wr_i = 1'b1; sr_wdata_i = v;
        @(negedge clk);
        sr_wr_i = 1'b0;
        check("R12", "sr after write", 32'(sr_o), 32'(v));
    endtask

    // entry already armed on inputs; observe the cycle after the edge
    task automatic observe_entry(logic [3:0] c, logic [31:0] pc, logic ds,
                                 logic sys, logic [15:0] old_sr);
        logic [31:0] exp_epc;
        exp_epc = pc - (ds ? 32'd4 : 32'd0) + (sys ? 32'd4 : 32'd0);
        @(negedge clk);
        take_i = 0; ext_irq_i = 0; tick_irq_i = 0; sr_wr_i = 0;
        check("R9",  "flush on entry", 32'(flush_o), 32'd1);
        check("R2",  "saved pc", epc_o, exp_epc);
        check("R4",  "saved sr", 32'(esr_o), 32'(old_sr));
        check("R5",  "sr after entry", 32'(sr_o), 32'(model_sr(old_sr, ds)));
        check("R3",  "dslot clear", 32'(dslot_clr_o), 32'(ds));
        check("R6",  "vector", npc_o, 32'(c) * 32'd256);
        check("R11", "cause during entry", 32'(cause_o), 32'(c));
        @(negedge clk);
        check("R9",  "flush drop", 32'(flush_o), 32'd0);
        check("R11", "cause idle", 32'(cause_o), 32'd0);
        check("R3",  "dslot clear drop", 32'(dslot_clr_o), 32'd0);
    endtask

    task automatic no_entry(string req, int cycles, logic [31:0] epc_keep);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            check(req, "no flush", 32'(flush_o), 32'd0);
            check(req, "epc kept", epc_o, epc_keep);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++; checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] old;
        logic [31:0] pc;
        do_reset();
        // R1 reset state
        check("R1", "sr reset", 32'(sr_o), 32'h0001);
        check("R1", "esr reset", 32'(esr_o), 0);
        check("R1", "epc reset", epc_o, 0);
        check("R1", "npc reset", npc_o, 0);
        check("R1", "cause reset", 32'(cause_o), 0);
        check("R1", "flush reset", 32'(flush_o), 0);
        check("R1", "err reset", 32'(err_o), 0);

        // synchronous sweep over every legal cause with and without delay slot
        for (int c = 1; c < 14; c++) begin
            for (int d = 0; d < 2; d++) begin
                write_sr(16'hA5DE ^ 16'(c << 8) ^ 16'(d << 5));
                old = sr_o;
                pc = 32'h1000_0000 + 32'(c * 64) + 32'(d * 8);
                pc_i = pc; dslot_i = d[0]; cause_i = 4'(c); take_i = 1'b1;
                observe_entry(4'(c), pc, d[0], c == 12, old);
            end
        end

        // R8 interrupt gating and priority
        dslot_i = 0; pc_i = 32'h0000_4000;
        write_sr(16'h0003);
        ext_irq_i = 1; tick_irq_i = 1;   // tick pending but disabled
        observe_entry(4'd8, 32'h0000_4000, 1'b0, 1'b0, 16'h0003);

        write_sr(16'h0005);
        ext_irq_i = 1;                    // ext pending but disabled
        no_entry("R8", 3, 32'h0000_4000);
        ext_irq_i = 0;

        pc_i = 32'h0000_5000;
        write_sr(16'h0007);
        ext_irq_i = 1; tick_irq_i = 1;
        observe_entry(4'd5, 32'h0000_5000, 1'b0, 1'b0, 16'h0007);

        pc_i = 32'h0000_5100; dslot_i = 1;
        write_sr(16'h0003);
        ext_irq_i = 1; tick_irq_i = 1;
        observe_entry(4'd8, 32'h0000_5100, 1'b1, 1'b0, 16'h0003);
        dslot_i = 0;

        write_sr(16'h0001);
        ext_irq_i = 1; tick_irq_i = 1;
        no_entry("R8", 3, 32'h0000_50FC);
        ext_irq_i = 0; tick_irq_i = 0;

        // R10 take beats interrupts and a status write
        pc_i = 32'h0000_6000;
        write_sr(16'h0007);
        ext_irq_i = 1; tick_irq_i = 1; take_i = 1; cause_i = 4'd3;
        sr_wr_i = 1; sr_wdata_i = 16'hFFFF;
        observe_entry(4'd3, 32'h0000_6000, 1'b0, 1'b0, 16'h0007);
        check("R10", "write lost to entry", 32'(sr_o), 32'(model_sr(16'h0007, 1'b0)));

        // R7 illegal causes
        for (int c = 0; c < 16; c++) begin
            if (c != 0 && c < 14) continue;
            do_reset();
            write_sr(16'h00FF);
            pc_i = 32'h0000_7000; take_i = 1; cause_i = 4'(c);
            @(negedge clk);
            take_i = 0;
            check("R7", "err raised", 32'(err_o), 1);
            check("R7", "no flush", 32'(flush_o), 0);
            check("R7", "sr kept", 32'(sr_o), 32'h00FF);
            check("R7", "epc kept", epc_o, 0);
            check("R7", "npc kept", npc_o, 0);
            take_i = 1; cause_i = 4'd2;
            @(negedge clk);
            take_i = 0;
            check("R7", "halted take ignored", 32'(flush_o), 0);
            ext_irq_i = 1; tick_irq_i = 1;
            no_entry("R7", 2, 0);
            ext_irq_i = 0; tick_irq_i = 0;
            sr_wr_i = 1; sr_wdata_i = 16'h1234;
            @(negedge clk);
            sr_wr_i = 0;
            check("R7", "halted write ignored", 32'(sr_o), 32'h00FF);
            check("R7", "err sticky", 32'(err_o), 1);
        end
        do_reset();
        check("R1", "err cleared by reset", 32'(err_o), 0);
        check("R1", "sr after reset", 32'(sr_o), 32'h0001);
        write_sr(16'h0003);
        pc_i = 32'h0000_8000; ext_irq_i = 1;
        observe_entry(4'd8, 32'h0000_8000, 1'b0, 1'b0, 16'h0003);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule